// File: doc/BRIEF.md
# Scalar memory request sequencer

The sequencer takes one 64-bit scalar-memory instruction word and expands it into a run of single-dword memory requests. On acceptance it splits the word into its fields. It checks the format tag and classifies the opcode as a plain load, a descriptor-based load or a store. Malformed words are flagged and produce no traffic. A legal instruction costs one cycle to read the base register pair and, when needed, the offset register through two read ports. The sequencer then computes a 48-bit start address and issues one request per dword on a valid/ready interface, with the byte address stepping by four.

Each request carries its byte address, a write flag, the scalar register that the dword belongs to, the coherence bit, and for stores the dword fetched through a third read port. A one-cycle done pulse marks the acceptance of the last request. A new instruction is accepted only while the sequencer is idle. The cache, the register file and the return-data path are outside the block.

Top module: `smem_req_seq`

## Requirements
- R1: After reset, instr_ready is 1 and req_valid, done, flag_bad_format, flag_bad_opcode and flag_bad_base are all 0.
- R2: An accepted word whose bits 31:26 differ from 6'b110000 raises flag_bad_format for exactly the cycle after acceptance and issues no request.
- R3: The opcode (bits 25:18) sets the burst length. Opcodes 0 to 4 (plain loads) and 8 to 12 (descriptor loads) issue 1, 2, 4, 8 and 16 read requests (req_write=0). Opcodes 16 to 18 issue 1, 2 and 4 write requests (req_write=1).
- R4: With a valid tag, any other opcode raises flag_bad_opcode in the cycle after acceptance and issues no request.
- R5: A descriptor load (opcodes 8 to 12) whose base register index (bits 5:0) is odd raises flag_bad_base in the cycle after acceptance and issues no request. Plain loads and stores accept odd indices.
- R6: When bit 17 is 1, the byte offset is bits 51:32, zero-extended. When bit 17 is 0, the byte offset is the 32-bit value read from the register named by bits 38:32 on the offset read port, zero-extended.
- R7: Request i of a burst has byte address (low 48 bits of the base pair read at index bits 5:0) + offset + 4*i, modulo 2^48. The upper 16 bits of the pair have no effect.
- R8: Request i carries req_reg = bits 12:6 plus i, modulo 128, and req_coherent = bit 16. For a store, req_wdata is the value read at req_reg on the data read port. For a load, req_wdata is 0.
- R9: While req_valid is 1 and req_ready is 0, every request output holds its value. The burst advances only on a cycle with both signals high.
- R10: instr_ready is 0 from the cycle after a legal acceptance until the burst ends. done is 1 for exactly the cycle after the last request handshake.
- R11: The flags have a fixed priority: a bad tag masks the opcode and base checks, and a bad opcode masks the base check. At most one flag is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_ready | output | 1 | Sequencer idle, word accepted this cycle if offered |
| instr_word | input | 64 | Scalar-memory instruction word |
| base_idx | output | 6 | Read-port index for the base register pair |
| base_val | input | 64 | Base pair value (low 48 bits address, upper 16 bits size) |
| off_idx | output | 7 | Read-port index for the offset register |
| off_val | input | 32 | Offset register value |
| data_idx | output | 7 | Read-port index for store data |
| data_val | input | 32 | Store data value |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request accepted by memory side |
| req_addr | output | 48 | Byte address of the dword |
| req_write | output | 1 | 1 for store, 0 for load |
| req_reg | output | 7 | Scalar register of this dword |
| req_wdata | output | 32 | Store data (0 for loads) |
| req_coherent | output | 1 | Coherence bit of the instruction |
| done | output | 1 | Pulse after the last request handshake |
| flag_bad_format | output | 1 | Pulse: wrong format tag |
| flag_bad_opcode | output | 1 | Pulse: unlisted opcode |
| flag_bad_base | output | 1 | Pulse: odd base index on a descriptor load |

## Verification
The hardest situation to reach from the ports is a long burst that is stalled partway, whose address carries across the top of the 48-bit space and whose register index wraps past 127 at the same time. The bench's register model places one base pair just below 2^48 and gives another a nonzero size field. The bench sweeps all 256 opcodes and toggles req_ready in an irregular pattern, so 16-dword bursts pause at many different points. Separate words cover the flag priorities, including a bad tag with a bad opcode and an odd base.

// File: rtl/smem_pkg.sv
// Shared field layout and classification types for the scalar-memory
// request sequencer. Assumes the fixed 64-bit instruction layout.
package smem_pkg;
    localparam int INSTR_W  = 64;
    localparam int BREG_FW  = 6;
    localparam int SREG_FW  = 7;
    localparam int OPC_W    = 8;
    localparam int OFF_FW   = 20;
    localparam logic [5:0] FMT_TAG = 6'b110000;

    typedef enum logic [1:0] {
        CLS_LOAD  = 2'd0,
        CLS_BUF   = 2'd1,
        CLS_STORE = 2'd2,
        CLS_NONE  = 2'd3
    } op_class_e;

    typedef struct packed {
        logic [BREG_FW-1:0] sbase;
        logic [SREG_FW-1:0] sdata;
        logic               coherent;
        logic               imm;
        logic [OPC_W-1:0]   opcode;
        logic [5:0]         tag;
        logic [OFF_FW-1:0]  offset;
    } smem_fields_t;
endpackage

// File: rtl/smem_decode.sv
// Splits an instruction word into fields and classifies it.
// Assumes: purely combinational; the caller registers what it keeps.
module smem_decode
    import smem_pkg::*;
(
    input  logic [INSTR_W-1:0] word,
    output smem_fields_t       fields,
    output logic               fmt_ok,
    output logic               op_ok,
    output logic               base_ok,
    output logic               is_write,
    output logic [2:0]         dw_log2
);
    op_class_e  cls;
    logic [4:0] grp;
    logic [2:0] lo;
    logic       unused_word;

    assign unused_word = ^{word[15:13], word[63:52]};

    // Field extraction at the fixed bit positions.
    always_comb begin
        fields.sbase    = word[5:0];
        fields.sdata    = word[12:6];
        fields.coherent = word[16];
        fields.imm      = word[17];
        fields.opcode   = word[25:18];
        fields.tag      = word[31:26];
        fields.offset   = word[51:32];
    end

    // Opcode grouping: upper five bits select the group, lower three the size.
    always_comb begin
        grp = fields.opcode[7:3];
        lo  = fields.opcode[2:0];
        cls = CLS_NONE;
        unique case (grp)
            5'd0:    cls = (lo <= 3'd4) ? CLS_LOAD  : CLS_NONE;
            5'd1:    cls = (lo <= 3'd4) ? CLS_BUF   : CLS_NONE;
            5'd2:    cls = (lo <= 3'd2) ? CLS_STORE : CLS_NONE;
            default: cls = CLS_NONE;
        endcase
        fmt_ok   = (fields.tag == FMT_TAG);
        op_ok    = (cls != CLS_NONE);
        base_ok  = !((cls == CLS_BUF) && fields.sbase[0]);
        is_write = (cls == CLS_STORE);
        dw_log2  = lo;
    end
endmodule

// File: rtl/smem_addr.sv
// Start-address adder: base pair low bits plus a zero-extended byte offset
// taken either from the immediate field or from an offset register.
// Assumes: register values are valid in the cycle they are sampled.
module smem_addr #(
    parameter int ADDR_W = 48,
    parameter int DATA_W = 32,
    parameter int OFF_W  = 20
) (
    input  logic [2*DATA_W-1:0] base_pair,
    input  logic                imm,
    input  logic [OFF_W-1:0]    off_imm,
    input  logic [DATA_W-1:0]   off_reg,
    output logic [ADDR_W-1:0]   start_addr
);
    logic [ADDR_W-1:0]          off_ext;
    logic                       unused_size;

    assign unused_size = ^base_pair[2*DATA_W-1:ADDR_W];

    // Offset source select and 48-bit add (wraps modulo 2^ADDR_W).
    always_comb begin
        off_ext    = imm ? ADDR_W'(off_imm) : ADDR_W'(off_reg);
        start_addr = base_pair[ADDR_W-1:0] + off_ext;
    end
endmodule

// File: rtl/smem_burst.sv
// Burst engine: fetch cycle, then one dword request per handshake.
// Assumes: start is pulsed only while idle; dw_total is 1..MAX_DW.
module smem_burst #(
    parameter int ADDR_W = 48,
    parameter int MAX_DW = 16,
    localparam int CNT_W = $clog2(MAX_DW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  dw_total,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              req_ready,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [CNT_W-1:0]  req_idx,
    output logic              busy,
    output logic              fetching,
    output logic              done
);
    typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_ISSUE} bst_e;

    bst_e              st_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  total_q;
    logic [ADDR_W-1:0] addr_q;
    logic              done_q;

    // State, counter and address progression.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            cnt_q   <= '0;
            total_q <= '0;
            addr_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        st_q    <= ST_FETCH;
                        total_q <= dw_total;
                    end
                end
                ST_FETCH: begin
                    addr_q <= start_addr;
                    cnt_q  <= '0;
                    st_q   <= ST_ISSUE;
                end
                ST_ISSUE: begin
                    if (req_ready) begin
                        if (cnt_q == total_q - CNT_W'(1)) begin
                            st_q   <= ST_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            cnt_q  <= cnt_q + CNT_W'(1);
                            addr_q <= addr_q + ADDR_W'(4);
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Output view of the engine state.
    always_comb begin
        req_valid = (st_q == ST_ISSUE);
        req_addr  = addr_q;
        req_idx   = cnt_q;
        busy      = (st_q != ST_IDLE);
        fetching  = (st_q == ST_FETCH);
        done      = done_q;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_idx))) // R9
        else $error("request changed while stalled");

    AST_DONE_AFTER_HS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(req_valid && req_ready)) // R10
        else $error("done without a preceding handshake");

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) // R10
        else $error("done longer than one cycle");
endmodule

// File: rtl/smem_req_seq.sv
// Scalar memory request sequencer top: accepts one instruction while idle,
// flags malformed words, reads base/offset registers for one cycle, then
// streams dword requests. Assumes register read ports are combinational.
module smem_req_seq
    import smem_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int DATA_W = 32,
    parameter int SREG_W = 7,
    parameter int BREG_W = 6,
    parameter int MAX_DW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                instr_valid,
    output logic                instr_ready,
    input  logic [63:0]         instr_word,
    output logic [BREG_W-1:0]   base_idx,
    input  logic [2*DATA_W-1:0] base_val,
    output logic [SREG_W-1:0]   off_idx,
    input  logic [DATA_W-1:0]   off_val,
    output logic [SREG_W-1:0]   data_idx,
    input  logic [DATA_W-1:0]   data_val,
    output logic                req_valid,
    input  logic                req_ready,
    output logic [ADDR_W-1:0]   req_addr,
    output logic                req_write,
    output logic [SREG_W-1:0]   req_reg,
    output logic [DATA_W-1:0]   req_wdata,
    output logic                req_coherent,
    output logic                done,
    output logic                flag_bad_format,
    output logic                flag_bad_opcode,
    output logic                flag_bad_base
);
    localparam int CNT_W = $clog2(MAX_DW + 1);

    smem_fields_t      dec_f;
    smem_fields_t      held_q;
    logic              fmt_ok, op_ok, base_ok, dec_wr;
    logic [2:0]        dec_log2;
    logic              accept, launch;
    logic              wr_q;
    logic              f_fmt_q, f_op_q, f_base_q;
    logic [CNT_W-1:0]  dw_total;
    logic [ADDR_W-1:0] start_addr;
    logic [CNT_W-1:0]  req_idx;
    logic              busy, fetching;

    smem_decode u_dec (
        .word     (instr_word),
        .fields   (dec_f),
        .fmt_ok   (fmt_ok),
        .op_ok    (op_ok),
        .base_ok  (base_ok),
        .is_write (dec_wr),
        .dw_log2  (dec_log2)
    );

    // Acceptance and launch conditions; burst length from the size code.
    always_comb begin
        accept   = instr_valid && instr_ready;
        launch   = accept && fmt_ok && op_ok && base_ok;
        dw_total = CNT_W'(1) << dec_log2;
    end

    // Hold the accepted fields and raise the one-cycle illegal flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q   <= '0;
            wr_q     <= 1'b0;
            f_fmt_q  <= 1'b0;
            f_op_q   <= 1'b0;
            f_base_q <= 1'b0;
        end else begin
            f_fmt_q  <= accept && !fmt_ok;
            f_op_q   <= accept && fmt_ok && !op_ok;
            f_base_q <= accept && fmt_ok && op_ok && !base_ok;
            if (launch) begin
                held_q <= dec_f;
                wr_q   <= dec_wr;
            end
        end
    end

    smem_addr #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .OFF_W  (OFF_FW)
    ) u_addr (
        .base_pair  (base_val),
        .imm        (held_q.imm),
        .off_imm    (held_q.offset),
        .off_reg    (off_val),
        .start_addr (start_addr)
    );

    smem_burst #(
        .ADDR_W (ADDR_W),
        .MAX_DW (MAX_DW)
    ) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (launch),
        .dw_total   (dw_total),
        .start_addr (start_addr),
        .req_ready  (req_ready),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_idx    (req_idx),
        .busy       (busy),
        .fetching   (fetching),
        .done       (done)
    );

    // Register-port indices and per-request attributes.
    always_comb begin
        instr_ready     = !busy;
        base_idx        = held_q.sbase;
        off_idx         = held_q.offset[SREG_W-1:0];
        req_reg         = held_q.sdata + SREG_W'(req_idx);
        data_idx        = req_reg;
        req_write       = wr_q;
        req_wdata       = wr_q ? data_val : '0;
        req_coherent    = held_q.coherent;
        flag_bad_format = f_fmt_q;
        flag_bad_opcode = f_op_q;
        flag_bad_base   = f_base_q;
    end

    AST_FLAG_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flag_bad_format, flag_bad_opcode, flag_bad_base})) // R11
        else $error("more than one illegal flag");

    AST_ILLEGAL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_bad_format || flag_bad_opcode || flag_bad_base) |-> (!req_valid && !fetching)) // R4
        else $error("illegal instruction started a burst");

    AST_STORE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |-> (req_idx < CNT_W'(4))) // R3
        else $error("store burst longer than four dwords");

    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        instr_ready |-> !req_valid) // R10
        else $error("instruction accepted during a burst");
endmodule

// File: tb/tb_smem_req_seq.sv
`timescale 1ns/1ps
module tb_smem_req_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic        instr_ready;
    logic [63:0] instr_word = '0;
    logic [5:0]  base_idx;
    logic [63:0] base_val;
    logic [6:0]  off_idx;
    logic [31:0] off_val;
    logic [6:0]  data_idx;
    logic [31:0] data_val;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [47:0] req_addr;
    logic        req_write;
    logic [6:0]  req_reg;
    logic [31:0] req_wdata;
    logic        req_coherent;
    logic        done;
    logic        f_fmt, f_op, f_base;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int ready_mode = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    smem_req_seq dut (
        .clk(clk), .rst_n(rst_n),
        .instr_valid(instr_valid), .instr_ready(instr_ready), .instr_word(instr_word),
        .base_idx(base_idx), .base_val(base_val),
        .off_idx(off_idx), .off_val(off_val),
        .data_idx(data_idx), .data_val(data_val),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_reg(req_reg), .req_wdata(req_wdata),
        .req_coherent(req_coherent), .done(done),
        .flag_bad_format(f_fmt), .flag_bad_opcode(f_op), .flag_bad_base(f_base)
    );

    function automatic logic [63:0] m_base(input logic [5:0] i);
        if (i == 6'd62) return {16'h5A5A, 48'hFFFF_FFFF_FFF8};
        return {16'hC3C3, 48'h0012_3400_0000 + 48'(i) * 48'h0000_0100_0000};
    endfunction
    function automatic logic [31:0] m_off(input logic [6:0] i);
        if (i == 7'd127) return 32'hFFFF_FFFC;
        return 32'(i) * 32'h0000_1011 + 32'h40;
    endfunction
    function automatic logic [31:0] m_data(input logic [6:0] i);
        return 32'hDA7A_0000 | (32'(i) * 32'h31);
    endfunction

    assign base_val = m_base(base_idx);
    assign off_val  = m_off(off_idx);
    assign data_val = m_data(data_idx);

    task automatic chk(input logic ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic logic ready_pat();
        if (ready_mode == 0) return 1'b1;
        return ((cyc % 5) != 1) && ((cyc % 7) != 3);
    endfunction

    task automatic run(input logic [7:0] op, input logic [5:0] sb, input logic [6:0] sd,
                       input logic g, input logic im, input logic [19:0] of, input logic [5:0] tag);
        logic [63:0] w;
        logic [2:0]  grp_lo;
        int          grp, n;
        logic        legal_op, is_buf, is_st, e_fmt, e_op, e_base;
        logic [47:0] off48, a_exp, hold_addr;
        logic        was_stall;
        int          k, guard;
        w = 64'hFFF0_0000_0000_E000;
        w[5:0] = sb; w[12:6] = sd; w[16] = g; w[17] = im;
        w[25:18] = op; w[31:26] = tag; w[51:32] = of;
        grp = int'(op >> 3); grp_lo = op[2:0];
        is_buf = (grp == 1) && (grp_lo <= 3'd4);
        is_st  = (grp == 2) && (grp_lo <= 3'd2);
        legal_op = ((grp == 0) && (grp_lo <= 3'd4)) || is_buf || is_st;
        n = 1 << grp_lo;
        e_fmt  = (tag != 6'b110000);
        e_op   = !e_fmt && !legal_op;
        e_base = !e_fmt && legal_op && is_buf && sb[0];
        off48  = im ? 48'(of) : 48'(m_off(of[6:0]));

        @(negedge clk);
        instr_valid = 1'b1; instr_word = w;
        #1 chk(instr_ready == 1'b1, "R10 idle ready before accept", 64'(instr_ready), 64'd1);
        @(negedge clk);
        instr_valid = 1'b0;
        #1;
        chk(f_fmt == e_fmt,   "R2 bad-format flag",  64'(f_fmt),  64'(e_fmt));
        chk(f_op == e_op,     "R4 bad-opcode flag",  64'(f_op),   64'(e_op));
        chk(f_base == e_base, "R5 bad-base flag R11", 64'(f_base), 64'(e_base));
        if (e_fmt || e_op || e_base) begin
            chk(!req_valid && instr_ready, "R4 illegal word issues nothing", 64'(req_valid), 64'd0);
            return;
        end
        chk(instr_ready == 1'b0, "R10 busy after legal accept", 64'(instr_ready), 64'd0);
        k = 0; guard = 0; was_stall = 1'b0; hold_addr = '0;
        while (!done && guard < 200) begin
            req_ready = ready_pat();
            #1;
            if (req_valid) begin
                if (was_stall)
                    chk(req_addr == hold_addr, "R9 address held under stall", 64'(req_addr), 64'(hold_addr));
                if (req_ready) begin
                    a_exp = m_base(sb)[47:0] + off48 + 48'(4 * k);
                    chk(req_addr == a_exp, "R7 R6 request address", 64'(req_addr), 64'(a_exp));
                    chk(req_write == is_st, "R3 direction", 64'(req_write), 64'(is_st));
                    chk(req_reg == 7'(sd + 7'(k)), "R8 register index", 64'(req_reg), 64'(7'(sd + 7'(k))));
                    chk(req_coherent == g, "R8 coherence bit", 64'(req_coherent), 64'(g));
                    chk(req_wdata == (is_st ? m_data(7'(sd + 7'(k))) : 32'd0), "R8 write data",
                        64'(req_wdata), 64'(is_st ? m_data(7'(sd + 7'(k))) : 32'd0));
                    k++;
                    was_stall = 1'b0;
                end else begin
                    was_stall = 1'b1;
                    hold_addr = req_addr;
                end
            end
            @(negedge clk);
            guard++;
        end
        req_ready = 1'b0;
        chk(done == 1'b1, "R10 done pulse seen", 64'(done), 64'd1);
        chk(k == n, "R3 burst length", 64'(k), 64'(n));
        @(negedge clk);
        #1 chk(done == 1'b0 && instr_ready == 1'b1, "R10 done one cycle, idle again", 64'(done), 64'd0);
    endtask

    initial begin
        #1_500_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(instr_ready == 1'b1, "R1 reset ready", 64'(instr_ready), 64'd1);
        chk(!req_valid && !done, "R1 reset request/done", 64'({req_valid, done}), 64'd0);
        chk(!f_fmt && !f_op && !f_base, "R1 reset flags", 64'({f_fmt, f_op, f_base}), 64'd0);
        rst_n = 1'b1;

        for (int pass = 0; pass < 2; pass++) begin
            ready_mode = pass;
            for (int op = 0; op < 256; op++) begin
                run(8'(op), 6'(op % 64), 7'((op * 5) % 128), op[2], op[1] ^ pass[0],
                    {8'(op), 12'hABC}, 6'b110000);
            end
        end
        ready_mode = 1;
        run(8'd4,  6'd62, 7'd120, 1'b1, 1'b1, 20'h0_0000, 6'b110000);
        run(8'd12, 6'd62, 7'd126, 1'b0, 1'b0, 20'h0_007F, 6'b110000);
        run(8'd18, 6'd3,  7'd127, 1'b1, 1'b0, 20'h0_007F, 6'b110000);
        run(8'd9,  6'd5,  7'd0,   1'b0, 1'b1, 20'h0_0010, 6'b110000);
        run(8'd0,  6'd0,  7'd0,   1'b0, 1'b1, 20'h0_0000, 6'b110001);
        run(8'd200, 6'd1, 7'd0,   1'b0, 1'b1, 20'h0_0000, 6'b010000);
        run(8'd9,  6'd1,  7'd0,   1'b0, 1'b1, 20'h0_0000, 6'b000000);
        run(8'd2,  6'd7,  7'd9,   1'b0, 1'b1, 20'hF_FFFF, 6'b110000);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule